// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block produces the active-low system reset for a processor core. The reset is held down while any reset source is active. After the last source goes away, the release is delayed through a chain of stabilisation stages. A power-up timer stage runs if it is enabled. An oscillator settling count runs if a crystal or resonator clock is selected. A frequency-multiplier lock wait runs if the multiplier is in use. A stage that is disabled adds no delay. Each stage length is a parameter counted in clock cycles. By default the settling stage is 1024 cycles.

There are four reset sources. Power-on enters through the block's asynchronous reset input. The external reset pin is a second source. The flag from an external supply-droop comparator is a third; the block passes that comparator a 2-bit threshold code. A wake-up or clock-switch request is the fourth. It is accepted only while the core is running, and it re-runs only the settling stage and the lock stage. A four-bit sticky cause register shows software which sources fired since it was last cleared.

Top module: `reset_sequencer`

## Requirements
- R1: After the power-on input `por_n` is released, `sys_rst_n` stays low for exactly PWRT_CYC (if `cfg_pwrt_en`) + OST_CYC (if `cfg_xtal`) + LOCK_CYC (if `cfg_pll`) clock edges beyond the first edge, and is then high.
- R2: A disabled stage contributes no cycles. With all three stages disabled, `sys_rst_n` rises at the first clock edge on which no source is active.
- R3: While `ext_rst_n` is low, `sys_rst_n` is low. When the pin returns high, the full staged delay of R1 runs again before release.
- R4: While `cfg_bor_en` is 1 and `bor_flag` is 1, `sys_rst_n` is low, and the full delay of R1 runs once the flag clears. With `cfg_bor_en` at 0 the flag has no effect.
- R5: A `wake_req` seen at a clock edge while `sys_rst_n` is high pulls `sys_rst_n` low for OST_CYC + LOCK_CYC (if `cfg_pll`) edges. A `wake_req` while reset is held is ignored: it neither lengthens the delay nor sets a cause bit.
- R6: If the pin or an enabled droop flag is asserted partway through a delay, the whole delay restarts from its first stage once that source is gone.
- R7: `cause` bits are: bit 0 power-on, bit 1 pin, bit 2 droop, bit 3 wake. Bits are sticky. Power-on leaves exactly 4'b0001.
- R8: A cycle with `cause_clr` high clears all cause bits. A source that is active in that same cycle still sets its bit.
- R9: `bor_sel` always equals `cfg_bor_level`.
- R10: `sys_rst_n` falls as soon as the pin or an enabled droop flag asserts, without waiting for a clock edge. It rises only at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| bor_flag | input | 1 | Supply-droop comparator output, 1 = below threshold |
| wake_req | input | 1 | Wake-up or clock-switch request |
| cfg_pwrt_en | input | 1 | Enable the power-up timer stage |
| cfg_xtal | input | 1 | Crystal/resonator mode: enable the settling stage |
| cfg_pll | input | 1 | Frequency multiplier in use: enable the lock stage |
| cfg_bor_en | input | 1 | Honour the droop flag |
| cfg_bor_level | input | 2 | Selected droop threshold code |
| cause_clr | input | 1 | Clear the cause register |
| sys_rst_n | output | 1 | System reset, active low |
| cause | output | 4 | Sticky reset-cause bits |
| bor_sel | output | 2 | Threshold code driven to the comparator |

## Verification
The hardest situation to reach is a source that interrupts a delay already under way, because it has to land inside a window that is many cycles long. The stimulus releases the pin, waits a set number of edges so that it is inside the power-up stage, and then drops the pin for a single cycle. The restarted delay is then measured from the pin's return. A wake request is also injected partway through a pin-started delay, and the total release time is checked to be unchanged. A reference model in the bench tracks the expected level and cause bits on every clock.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_PWRT,
    ST_OST,
    ST_LOCK,
    ST_RUN
  } stage_e;

  // first stage of a full (non-wake) sequence
  function automatic stage_e first_full(input logic pwrt_en, input logic xtal,
                                        input logic pll);
    stage_e s;
    if (pwrt_en)  s = ST_PWRT;
    else if (xtal) s = ST_OST;
    else if (pll)  s = ST_LOCK;
    else           s = ST_RUN;
    return s;
  endfunction

  // stage following a finished timed stage
  function automatic stage_e stage_after(input stage_e cur, input logic xtal,
                                         input logic pll);
    stage_e s;
    s = ST_RUN;
    case (cur)
      ST_PWRT: s = xtal ? ST_OST : (pll ? ST_LOCK : ST_RUN);
      ST_OST:  s = pll ? ST_LOCK : ST_RUN;
      default: s = ST_RUN;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int PWRT_CYC = 730,
  parameter int OST_CYC  = 1024,
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic por_n,
  input  logic hold_i,
  input  logic wake_i,
  input  logic pwrt_en_i,
  input  logic xtal_i,
  input  logic pll_i,
  output logic run_o,
  output logic wake_go_o
);

  localparam int MAX_A = (PWRT_CYC > OST_CYC) ? PWRT_CYC : OST_CYC;
  localparam int MAXL  = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
  localparam int CW    = $clog2(MAXL + 1);

  stage_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          in_timed;

  function automatic logic [CW-1:0] load_for(input stage_e s);
    logic [CW-1:0] v;
    case (s)
      ST_PWRT: v = CW'(PWRT_CYC - 1);
      ST_OST:  v = CW'(OST_CYC - 1);
      ST_LOCK: v = CW'(LOCK_CYC - 1);
      default: v = '0;
    endcase
    return v;
  endfunction

  assign in_timed  = (st_q == ST_PWRT) || (st_q == ST_OST) || (st_q == ST_LOCK);
  assign run_o     = (st_q == ST_RUN);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    wake_go_o = 1'b0;
    if (hold_i) begin
      st_d  = ST_HOLD;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_HOLD: begin
          st_d  = first_full(pwrt_en_i, xtal_i, pll_i);
          cnt_d = load_for(st_d);
        end
        ST_PWRT, ST_OST, ST_LOCK: begin
          if (cnt_q == '0) begin
            st_d  = stage_after(st_q, xtal_i, pll_i);
            cnt_d = load_for(st_d);
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        ST_RUN: begin
          if (wake_i) begin
            st_d      = ST_OST;
            cnt_d     = load_for(ST_OST);
            wake_go_o = 1'b1;
          end
        end
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R3 / R4 / R6: an active source parks the sequencer
  a_r6_source_restarts: assert property (@(posedge clk) disable iff (!por_n)
    hold_i |=> (st_q == ST_HOLD));

  // R1: a timed stage counts down by one per cycle without leaving the stage
  a_r1_count_down: assert property (@(posedge clk) disable iff (!por_n)
    (in_timed && cnt_q != '0 && !hold_i) |=>
      (cnt_q == $past(cnt_q) - CW'(1)) && (st_q == $past(st_q)));

  // R1 / R2: release only from a finished stage or an all-disabled start
  a_r2_release_point: assert property (@(posedge clk) disable iff (!por_n)
    $rose(run_o) |-> $past(st_q == ST_HOLD || cnt_q == '0));

  // R5: an accepted wake leaves the run state
  a_r5_wake_drops: assert property (@(posedge clk) disable iff (!por_n)
    wake_go_o |=> !run_o);

endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_i,
  output logic [NSRC-1:0] cause_o
);

  localparam logic [NSRC-1:0] POR_ONLY = NSRC'(1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause_o <= POR_ONLY;
    else        cause_o <= (clr_i ? '0 : cause_o) | set_i;
  end

  // R7: bits stay set until a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!por_n)
    !clr_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

  // R8: set wins over a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!por_n)
    (set_i != '0) |=> ((cause_o & $past(set_i)) == $past(set_i)));

  // R8: a clear with no source empties the register
  a_r8_clear: assert property (@(posedge clk) disable iff (!por_n)
    (clr_i && set_i == '0) |=> (cause_o == '0));

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int PWRT_CYC = 730,
  parameter int OST_CYC  = 1024,
  parameter int LOCK_CYC = 200
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       bor_flag,
  input  logic       wake_req,
  input  logic       cfg_pwrt_en,
  input  logic       cfg_xtal,
  input  logic       cfg_pll,
  input  logic       cfg_bor_en,
  input  logic [1:0] cfg_bor_level,
  input  logic       cause_clr,
  output logic       sys_rst_n,
  output logic [3:0] cause,
  output logic [1:0] bor_sel
);

  logic pin_active, bor_active, hold_src, run, wake_go;
  logic [3:0] cause_set;

  assign pin_active = !ext_rst_n;
  assign bor_active = cfg_bor_en && bor_flag;
  assign hold_src   = pin_active || bor_active;

  rstseq_fsm #(
    .PWRT_CYC(PWRT_CYC),
    .OST_CYC (OST_CYC),
    .LOCK_CYC(LOCK_CYC)
  ) u_fsm (
    .clk      (clk),
    .por_n    (por_n),
    .hold_i   (hold_src),
    .wake_i   (wake_req),
    .pwrt_en_i(cfg_pwrt_en),
    .xtal_i   (cfg_xtal),
    .pll_i    (cfg_pll),
    .run_o    (run),
    .wake_go_o(wake_go)
  );

  assign cause_set = {wake_go, bor_active, pin_active, 1'b0};

  rstseq_cause #(.NSRC(4)) u_cause (
    .clk    (clk),
    .por_n  (por_n),
    .set_i  (cause_set),
    .clr_i  (cause_clr),
    .cause_o(cause)
  );

  // R10: asynchronous assertion, clocked release
  assign sys_rst_n = run && !hold_src;
  assign bor_sel   = cfg_bor_level;

  // R10: release happens only when the sequencer's run flag rose at an edge
  a_r10_clocked_release: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> $rose(run) || $fell(hold_src));

endmodule

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P_CYC = 40;
  localparam int O_CYC = 24;
  localparam int L_CYC = 12;

  logic clk = 0, por_n = 0, ext_rst_n = 1, bor_flag = 0, wake_req = 0;
  logic cfg_pwrt_en = 1, cfg_xtal = 1, cfg_pll = 1, cfg_bor_en = 1;
  logic [1:0] cfg_bor_level = 2'd2;
  logic cause_clr = 0;
  logic sys_rst_n;
  logic [3:0] cause;
  logic [1:0] bor_sel;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_sequencer #(.PWRT_CYC(P_CYC), .OST_CYC(O_CYC), .LOCK_CYC(L_CYC)) u_reset_sequencer (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .bor_flag(bor_flag),
    .wake_req(wake_req), .cfg_pwrt_en(cfg_pwrt_en), .cfg_xtal(cfg_xtal),
    .cfg_pll(cfg_pll), .cfg_bor_en(cfg_bor_en), .cfg_bor_level(cfg_bor_level),
    .cause_clr(cause_clr), .sys_rst_n(sys_rst_n), .cause(cause), .bor_sel(bor_sel)
  );

  function automatic int full_delay();
    int d = 0;
    if (cfg_pwrt_en) d += P_CYC;
    if (cfg_xtal)    d += O_CYC;
    if (cfg_pll)     d += L_CYC;
    return d;
  endfunction

  function automatic int wake_delay();
    return O_CYC + (cfg_pll ? L_CYC : 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: 0 held, 1 counting, 2 running
  int m_state = 0, m_rem = 0;
  logic [3:0] m_cause = 4'b0001;
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_state = 0; m_rem = 0; m_cause = 4'b0001;
    end else begin
      logic hold;
      logic [3:0] nc;
      hold = !ext_rst_n || (cfg_bor_en && bor_flag);
      nc = cause_clr ? 4'b0 : m_cause;
      if (!ext_rst_n) nc[1] = 1'b1;
      if (cfg_bor_en && bor_flag) nc[2] = 1'b1;
      if (hold) m_state = 0;
      else if (m_state == 0) begin
        m_rem = full_delay();
        m_state = (m_rem == 0) ? 2 : 1;
      end else if (m_state == 1) begin
        m_rem--;
        if (m_rem == 0) m_state = 2;
      end else if (wake_req) begin
        m_rem = wake_delay(); m_state = 1; nc[3] = 1'b1;
      end
      m_cause = nc;
    end
  end

  always @(negedge clk) begin
    logic exp_rst;
    exp_rst = (m_state == 2) && ext_rst_n && !(cfg_bor_en && bor_flag);
    check({cur_req, " model rst"}, int'(sys_rst_n), int'(exp_rst));
    check({cur_req, " model cause"}, int'(cause), int'(m_cause));
    check("R9 model bor_sel", int'(bor_sel), int'(cfg_bor_level));
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // counts edges until release; clears a one-cycle wake after the first edge
  task automatic measure(output int n);
    n = 0;
    do begin
      @(posedge clk); #2;
      wake_req = 0;
      n++;
    end while (!sys_rst_n && n < 5000);
  endtask

  task automatic pin_pulse(input int low_cycles);
    ext_rst_n = 0; step(low_cycles); ext_rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, n2;
    step(3);
    cur_req = "R7";
    check("R7 reset level", int'(sys_rst_n), 0);
    check("R7 power-on cause", int'(cause), 4'b0001);
    cur_req = "R1";
    por_n = 1;
    measure(n);
    check("R1 power-on delay", n, P_CYC + O_CYC + L_CYC + 1);
    check("R9 bor_sel", int'(bor_sel), 2);
    cfg_bor_level = 2'd1; #1;
    check("R9 bor_sel change", int'(bor_sel), 1);

    cur_req = "R8";
    cause_clr = 1; step(1); cause_clr = 0;
    check("R8 clear", int'(cause), 0);

    cur_req = "R10";
    step(2);
    ext_rst_n = 0; #1;
    check("R10 async pin assert", int'(sys_rst_n), 0);
    step(4);
    cur_req = "R3";
    check("R3 pin cause", int'(cause), 4'b0010);
    ext_rst_n = 1;
    measure(n);
    check("R3 pin full delay", n, P_CYC + O_CYC + L_CYC + 1);

    cur_req = "R2";
    cfg_pwrt_en = 0; cfg_xtal = 0; cfg_pll = 0;
    pin_pulse(2); measure(n);
    check("R2 all stages off", n, 1);
    cfg_xtal = 1;
    pin_pulse(2); measure(n);
    check("R2 settle only", n, O_CYC + 1);
    cfg_pwrt_en = 1; cfg_xtal = 0; cfg_pll = 1;
    pin_pulse(2); measure(n);
    check("R2 timer plus lock", n, P_CYC + L_CYC + 1);
    cfg_xtal = 1;

    cur_req = "R4";
    cause_clr = 1; step(1); cause_clr = 0;
    bor_flag = 1; #1;
    check("R4 droop async hold", int'(sys_rst_n), 0);
    step(5);
    check("R4 droop cause", int'(cause), 4'b0100);
    bor_flag = 0;
    measure(n);
    check("R4 droop full delay", n, P_CYC + O_CYC + L_CYC + 1);
    cause_clr = 1; step(1); cause_clr = 0;
    cfg_bor_en = 0; bor_flag = 1;
    step(6);
    check("R4 disabled flag ignored", int'(sys_rst_n), 1);
    check("R4 disabled no cause", int'(cause), 0);
    bor_flag = 0; cfg_bor_en = 1;

    cur_req = "R5";
    wake_req = 1; measure(n);
    check("R5 wake with lock", n, O_CYC + L_CYC + 1);
    check("R5 wake cause", int'(cause), 4'b1000);
    cfg_pll = 0;
    wake_req = 1; measure(n);
    check("R5 wake settle only", n, O_CYC + 1);
    cfg_pll = 1;

    pin_pulse(2);
    cause_clr = 1; step(1); cause_clr = 0;
    step(4); wake_req = 1; step(1); wake_req = 0; step(4);
    measure(n2);
    check("R5 wake while held ignored", 1 + 4 + 1 + 4 + n2, P_CYC + O_CYC + L_CYC + 1);
    check("R5 ignored wake no cause", int'(cause), 0);

    cur_req = "R6";
    ext_rst_n = 0; step(3); ext_rst_n = 1;
    step(30);
    check("R6 mid-sequence held", int'(sys_rst_n), 0);
    pin_pulse(1); measure(n);
    check("R6 pin restart", n, P_CYC + O_CYC + L_CYC + 1);
    ext_rst_n = 0; step(2); ext_rst_n = 1;
    step(50);
    bor_flag = 1; step(1); bor_flag = 0;
    measure(n);
    check("R6 droop restart", n, P_CYC + O_CYC + L_CYC + 1);

    cur_req = "R8";
    cause_clr = 1; ext_rst_n = 0; step(1); cause_clr = 0; ext_rst_n = 1;
    check("R8 set beats clear", int'(cause[1]), 1);
    measure(n);

    cur_req = "R7";
    por_n = 0; #1;
    check("R7 por async", int'(sys_rst_n), 0);
    check("R7 por cause", int'(cause), 4'b0001);
    step(2); por_n = 1;
    measure(n);
    check("R1 second power-on", n, P_CYC + O_CYC + L_CYC + 1);
    step(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule